// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filtering

This block receives asynchronous serial frames on a shared multidrop line. Each frame carries, after its eight data bits, one extra flag bit that tells address frames (flag 1) from data frames (flag 0). Software can arm a hardware filter through a control register. While the filter is armed, the receiver silently drops data frames. The first address frame is loaded into the receive data register and raises the receive interrupt, and the filter disarms itself. Software then compares the received address with its own station number. If they match, it goes on to take the data frames that follow. If they do not match, it re-arms the filter and waits for the next address.

Bit timing comes from an external oversampling tick at sixteen times the bit rate. Software reaches the block through a small register port: a data register, a control register and a status register. The block also exposes the held byte and an interrupt line.

Top module: `mprx_top`

## Requirements
- R1: A frame is a start bit of 0, then eight data bits with the least significant bit first, then the address flag bit, then a stop bit of 1. The line idles at 1.
- R2: The line passes through a two-stage synchronizer. A falling edge is confirmed as a start bit by a sample taken eight ticks later. If that sample reads 1, the edge is dropped as a glitch and nothing is received.
- R3: While the filter is disarmed, every well-formed frame loads its byte into the data register and sets the full flag, whatever its flag bit. The received flag bit is kept in status bit 3.
- R4: While the filter is armed, a frame whose flag bit is 0 leaves the data register, the full flag, the other status flags and the interrupt output unchanged.
- R5: While the filter is armed, a well-formed frame whose flag bit is 1 loads the data register, sets the full flag and disarms the filter.
- R6: A read of the data register (address 0 with the read strobe) clears the full flag. Software may re-arm the filter at any time by writing the control register.
- R7: A frame whose stop bit samples as 0 and that is not dropped by the filter sets the framing-error flag and is not loaded.
- R8: A frame that would be loaded while the full flag is still set sets the overrun flag and leaves the data register unchanged.
- R9: The interrupt output is high exactly when the full flag and the interrupt-enable bit are both set.
- R10: A control write that sets the filter bit in the same cycle as a hardware disarm caused by a loaded address frame loses: the filter ends disarmed. The interrupt-enable bit of that write still takes effect.
- R11: Register map. Address 0 reads the data register. Address 1 is control, with bit 0 the filter enable and bit 1 the interrupt enable. Address 2 is status, with bit 0 full, bit 1 overrun, bit 2 framing error and bit 3 the last loaded flag bit. Writing 1 to status bit 1 or bit 2 clears that flag.
- R12: After reset, every register and flag is 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input |
| os_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears full on address 0) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| rx_data | output | 8 | Currently held received byte |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
On every cycle, the assertions check the following. A dropped frame leaves the data register and full flag alone. A loaded address frame disarms the filter. An overrun or framing event sets its flag without touching the data register. A confirmed glitch returns the bit engine to idle, and the frame-valid pulse lasts a single cycle. Only the bench scenarios can show the rest. These are the bit ordering and byte values seen at the ports, the full sequence of arm, match and re-arm, the interrupt gating, and the cycle-exact collision between a control write and the hardware disarm.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

    localparam int DATA_BITS   = 8;
    localparam int OS_RATE     = 16;
    localparam int SYNC_STAGES = 2;
    localparam int ADDR_W      = 2;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic                 stop_ok;
        logic                 addr_flag;
        logic [DATA_BITS-1:0] data;
    } rx_frame_t;

    typedef struct packed {
        logic skip;
        logic load;
        logic ovr_set;
        logic ferr_set;
        logic id_clr;
    } rx_action_t;

    typedef struct packed {
        logic filt_en;
        logic irq_en;
    } rx_ctrl_t;

    function automatic logic [DATA_BITS-1:0] pack_status(
        input logic full, input logic ovr, input logic ferr, input logic flag);
        logic [DATA_BITS-1:0] s;
        s    = '0;
        s[0] = full;
        s[1] = ovr;
        s[2] = ferr;
        s[3] = flag;
        return s;
    endfunction

endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
    parameter int STAGES = mprx_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mprx_deser.sv
module mprx_deser import mprx_pkg::*; #(
    parameter int OSR = OS_RATE
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_s,
    input  logic      tick,
    output logic      fr_valid,
    output rx_frame_t fr
);
    localparam int CW  = $clog2(OSR);
    localparam int SHW = DATA_BITS + 1;
    localparam int IW  = $clog2(SHW);
    localparam logic [CW-1:0] HALF = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [IW-1:0] IDX_END = IW'(SHW - 1);

    rx_state_e      state_q;
    logic [CW-1:0]  cnt_q;
    logic [IW-1:0]  idx_q;
    logic [SHW-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            idx_q    <= '0;
            sh_q     <= '0;
            fr_valid <= 1'b0;
            fr       <= '0;
        end else begin
            fr_valid <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (!rx_s) begin
                            state_q <= ST_START;
                            cnt_q   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt_q == HALF) begin
                            cnt_q <= '0;
                            idx_q <= '0;
                            state_q <= rx_s ? ST_IDLE : ST_BITS;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_BITS: begin
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            sh_q  <= {rx_s, sh_q[SHW-1:1]};
                            if (idx_q == IDX_END) state_q <= ST_STOP;
                            else                  idx_q   <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt_q == LAST) begin
                            cnt_q        <= '0;
                            fr_valid     <= 1'b1;
                            fr.stop_ok   <= rx_s;
                            fr.addr_flag <= sh_q[SHW-1];
                            fr.data      <= sh_q[DATA_BITS-1:0];
                            state_q      <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R2: a start edge that reads 1 at mid-bit returns to idle
    a_r2_glitch_reject: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && tick && cnt_q == HALF && rx_s) |=> (state_q == ST_IDLE && !fr_valid));

    // R1: each received frame is reported by a single-cycle pulse
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fr_valid |=> !fr_valid);
endmodule

// File: rtl/mprx_filter.sv
module mprx_filter import mprx_pkg::*; (
    input  logic       fr_valid,
    input  rx_frame_t  fr,
    input  logic       filt_en,
    input  logic       full,
    output rx_action_t act
);
    logic qualify;

    always_comb begin
        act.skip     = fr_valid && filt_en && !fr.addr_flag;
        qualify      = fr_valid && !act.skip && fr.stop_ok;
        act.ferr_set = fr_valid && !act.skip && !fr.stop_ok;
        act.ovr_set  = qualify && full;
        act.load     = qualify && !full;
        act.id_clr   = act.load && filt_en && fr.addr_flag;
    end
endmodule

// File: rtl/mprx_regs.sv
module mprx_regs import mprx_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fr_valid,
    input  rx_frame_t            fr,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_BITS-1:0] wdata,
    output logic [DATA_BITS-1:0] rdata,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 irq
);
    rx_ctrl_t             ctrl_q;
    logic [DATA_BITS-1:0] data_q;
    logic                 full_q, ovr_q, ferr_q, flag_q;
    rx_action_t           act;
    logic                 unused_wbits;

    assign unused_wbits = ^wdata[DATA_BITS-1:3];

    mprx_filter u_filter (
        .fr_valid (fr_valid),
        .fr       (fr),
        .filt_en  (ctrl_q.filt_en),
        .full     (full_q),
        .act      (act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            data_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            ferr_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr && addr == ADDR_CTRL) begin
                ctrl_q.filt_en <= wdata[0];
                ctrl_q.irq_en  <= wdata[1];
            end
            if (act.id_clr) ctrl_q.filt_en <= 1'b0;

            if (wr && addr == ADDR_STAT) begin
                if (wdata[1]) ovr_q  <= 1'b0;
                if (wdata[2]) ferr_q <= 1'b0;
            end
            if (act.ovr_set)  ovr_q  <= 1'b1;
            if (act.ferr_set) ferr_q <= 1'b1;

            if (rd && addr == ADDR_DATA) full_q <= 1'b0;
            if (act.load) begin
                data_q <= fr.data;
                flag_q <= fr.addr_flag;
                full_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_DATA: rdata = data_q;
            ADDR_CTRL: rdata = {{(DATA_BITS-2){1'b0}}, ctrl_q.irq_en, ctrl_q.filt_en};
            ADDR_STAT: rdata = pack_status(full_q, ovr_q, ferr_q, flag_q);
            default:   rdata = '0;
        endcase
    end

    assign rx_data = data_q;
    assign irq     = full_q && ctrl_q.irq_en;

    a_r4_skip_holds: assert property (@(posedge clk) disable iff (rst)
        (act.skip && !(rd && addr == ADDR_DATA)) |=> ($stable(data_q) && $stable(full_q)));

    a_r5_id_disarms: assert property (@(posedge clk) disable iff (rst)
        act.id_clr |=> !ctrl_q.filt_en);

    a_r3_load_value: assert property (@(posedge clk) disable iff (rst)
        (fr_valid && !ctrl_q.filt_en && fr.stop_ok && !full_q) |=> (full_q && data_q == $past(fr.data)));

    a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
        act.ovr_set |=> (ovr_q && $stable(data_q)));

    a_r7_framing_keeps: assert property (@(posedge clk) disable iff (rst)
        act.ferr_set |=> (ferr_q && $stable(data_q)));
endmodule

// File: rtl/mprx_top.sv
module mprx_top import mprx_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    input  logic                 os_tick,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_BITS-1:0] reg_wdata,
    output logic [DATA_BITS-1:0] reg_rdata,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_irq
);
    logic      rx_s;
    logic      fr_valid;
    rx_frame_t fr;

    mprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (rx_s)
    );

    mprx_deser #(.OSR(OS_RATE)) u_deser (
        .clk      (clk),
        .rst      (rst),
        .rx_s     (rx_s),
        .tick     (os_tick),
        .fr_valid (fr_valid),
        .fr       (fr)
    );

    mprx_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .fr_valid (fr_valid),
        .fr       (fr),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .rx_data  (rx_data),
        .irq      (rx_irq)
    );
endmodule

// File: tb/tb_mprx_top.sv
`timescale 1ns/1ps
module tb_mprx_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [7:0] rx_data;
    logic       rx_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_data = 8'd0;
    logic m_full = 0, m_ovr = 0, m_ferr = 0, m_flag = 0, m_filt = 0, m_ie = 0;

    always #2 clk = ~clk;

    mprx_top dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_data(rx_data), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, input bit strobe, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = strobe;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    function automatic logic [7:0] exp_status();
        return {4'b0, m_flag, m_ferr, m_ovr, m_full};
    endfunction

    function automatic string tag_for(input logic flag, input logic stop);
        if (m_filt && !flag) return "R4";
        if (!stop)           return "R7";
        if (m_full)          return "R8";
        if (m_filt)          return "R5";
        return "R3";
    endfunction

    task automatic model_frame(input logic [7:0] d, input logic flag, input logic stop);
        if (m_filt && !flag) return;
        if (!stop) begin m_ferr = 1; return; end
        if (m_full) begin m_ovr = 1; return; end
        m_data = d; m_flag = flag; m_full = 1;
        if (m_filt) m_filt = 0;
    endtask

    // ticks every 4 clocks; stop bit is sampled on tick 169 of the frame
    task automatic send_frame(input logic [7:0] d, input logic flag, input logic stop,
                              input bit collide, input logic [7:0] cwd);
        logic [10:0] bits;
        bits = {stop, flag, d, 1'b0};
        for (int t = 0; t < 176; t++) begin
            @(negedge clk); rx_line = bits[t/16]; os_tick = 1'b1;
            @(negedge clk); os_tick = 1'b0;
            if (collide && t == 169) begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = cwd; end
            @(negedge clk); reg_wr = 1'b0;
            @(negedge clk);
        end
        rx_line = 1'b1;
    endtask

    task automatic send_glitch();
        for (int t = 0; t < 32; t++) begin
            @(negedge clk); rx_line = (t < 4) ? 1'b0 : 1'b1; os_tick = 1'b1;
            @(negedge clk); os_tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        rd_reg(2'd2, 1'b0, v); chk(tag, "status", v, exp_status());
        rd_reg(2'd1, 1'b0, v); chk(tag, "ctrl", v, {6'b0, m_ie, m_filt});
        rd_reg(2'd0, 1'b0, v); chk(tag, "data reg", v, m_data);
        chk(tag, "rx_data port", rx_data, m_data);
        chk("R9", "irq", {7'b0, rx_irq}, {7'b0, m_full & m_ie});
    endtask

    task automatic read_clear();
        logic [7:0] v;
        rd_reg(2'd0, 1'b1, v);
        chk("R6", "data on read", v, m_data);
        m_full = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        check_all("R12");

        // R1 / R3: filter off, data frame loaded LSB first
        send_frame(8'hA5, 1'b0, 1'b1, 0, 8'h0);
        model_frame(8'hA5, 1'b0, 1'b1);
        check_all("R1");

        // R9: enable interrupt, then R6 read clears full
        m_ie = 1; wr_reg(2'd1, 8'h02);
        check_all("R9");
        read_clear();
        check_all("R6");

        // R4: armed filter skips a data frame
        m_filt = 1; wr_reg(2'd1, 8'h03);
        send_frame(8'h3C, 1'b0, 1'b1, 0, 8'h0);
        model_frame(8'h3C, 1'b0, 1'b1);
        check_all("R4");

        // R5: address frame loaded and disarms
        send_frame(8'h81, 1'b1, 1'b1, 0, 8'h0);
        model_frame(8'h81, 1'b1, 1'b1);
        check_all("R5");
        read_clear();

        // R6: re-arm after mismatch then data is skipped again
        m_filt = 1; wr_reg(2'd1, 8'h03);
        send_frame(8'h11, 1'b0, 1'b1, 0, 8'h0);
        model_frame(8'h11, 1'b0, 1'b1);
        check_all("R6");

        // R2: glitch is dropped, then a valid address frame arrives
        send_glitch();
        check_all("R2");
        send_frame(8'h5A, 1'b1, 1'b1, 0, 8'h0);
        model_frame(8'h5A, 1'b1, 1'b1);
        check_all("R2");
        read_clear();

        // R10: control write with filter=1, ie=0 collides with hardware disarm
        m_filt = 1; wr_reg(2'd1, 8'h03);
        send_frame(8'hC3, 1'b1, 1'b1, 1, 8'h01);
        m_ie = 0;
        model_frame(8'hC3, 1'b1, 1'b1);
        check_all("R10");

        // R8: overrun while full; R7: framing error
        send_frame(8'h77, 1'b0, 1'b1, 0, 8'h0);
        model_frame(8'h77, 1'b0, 1'b1);
        check_all("R8");
        send_frame(8'h99, 1'b0, 1'b0, 0, 8'h0);
        model_frame(8'h99, 1'b0, 1'b0);
        check_all("R7");

        // R11: write-one-to-clear of overrun and framing flags
        wr_reg(2'd2, 8'h06);
        m_ovr = 0; m_ferr = 0;
        check_all("R11");
        read_clear();

        // constrained random frames
        for (int i = 0; i < 36; i++) begin
            logic [7:0] d;
            logic flag, stop;
            string tag;
            if ($urandom % 3 == 0) begin
                m_filt = 1; m_ie = 1'($urandom % 2);
                wr_reg(2'd1, {6'b0, m_ie, 1'b1});
            end
            d    = 8'($urandom);
            flag = 1'($urandom % 2);
            stop = ($urandom % 8) != 0;
            tag  = tag_for(flag, stop);
            send_frame(d, flag, stop, 0, 8'h0);
            model_frame(d, flag, stop);
            check_all(tag);
            if ($urandom % 2 == 0) read_clear();
            if ($urandom % 4 == 0) begin
                wr_reg(2'd2, 8'h06);
                m_ovr = 0; m_ferr = 0;
                rd_reg(2'd2, 1'b0, v);
                chk("R11", "status after clear", v, exp_status());
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule